// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two levels of translation entries from memory. A privileged table-base register gives the physical address of the first-level table. The upper index bits of the virtual address pick an entry in that table. The entry's page number gives the base of a second-level table, and the middle index bits pick the leaf entry there. The leaf's page number joined with the untouched page offset forms the result.

Each walk starts with a valid/ready request that carries the address and a load/store flag. The walk issues single-word reads on a simple memory port with one request pulse per access. A walk either ends with a physical address, or stops early with a page fault (an invalid entry) or a protection fault (the leaf forbids the access). When a walk succeeds, the block keeps the leaf's reference and modified bits current by writing the entry back. It does this only when one of those bits actually changes.

Top module: `pt_walker`

## Requirements
- R1: Entry format, the same at both levels: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 referenced, bit 4 modified, and the top PA_W-OFF_W bits hold the physical page number. On success, `paddr` is the leaf page number concatenated with the low OFF_W bits of the virtual address. The offset passes through unchanged.
- R2: The first memory read goes to table base + first-level index × 4, where the first-level index is the top L1_W bits. The second read goes to (first-level page number << OFF_W) + second-level index × 4, where the second-level index is the L2_W bits just above the offset.
- R3: Reset clears the table base to 0. A base write with `base_kernel` = 1 takes effect, and a write with `base_kernel` = 0 leaves the base unchanged.
- R4: A first-level entry with bit 0 clear ends the walk after one memory access with status page fault.
- R5: A leaf entry with bit 0 clear ends the walk after two memory accesses with status page fault.
- R6: A load needs the readable bit and a store needs the writable bit. If the needed bit is clear, the walk ends after two accesses with status protection fault and the entry is not written.
- R7: A successful walk sets the referenced bit in the leaf, and a store walk also sets the modified bit. The block writes the updated leaf to the leaf's own address as a third access only if this changes the entry. Otherwise the walk ends after two accesses.
- R8: `done` is a one-cycle pulse. `status` carries 0 = ok, 1 = page fault, 2 = protection fault. `paddr` is 0 on a fault.
- R9: `req_ready` is high only while idle and drops for the whole walk. After reset the block is idle with `done`, `mem_req`, `status` and `paddr` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Table-base write strobe |
| base_kernel | input | 1 | Privileged-mode flag for the base write |
| base_wdata | input | PA_W | New table base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | L1_W+L2_W+OFF_W | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load |
| done | output | 1 | Result pulse |
| status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| paddr | output | PA_W | Translated physical address |
| mem_req | output | 1 | Memory access pulse |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PA_W | Byte address of the entry word |
| mem_wdata | output | WORD_W | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Access complete, read data valid |
| mem_rdata | input | WORD_W | Entry word read |

## Verification
The bench keeps the default sizes: 10-bit indices, a 12-bit offset, and 32-bit addresses and entries. It places the first-level table and two second-level tables in the lowest 16 KB of a word array that answers one cycle after each request. With these sizes, table addresses stay small while the leaf page numbers can be arbitrary 20-bit values. The offset extremes 0x000 and 0xFFF are covered, as is a second table reached through a different first-level entry. Repeating a walk shows the write-back disappearing once the referenced bit is already set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    XS_OK    = 2'd0,
    XS_PGFLT = 2'd1,
    XS_PROT  = 2'd2
  } xlat_status_e;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_U = 3;
  localparam int BIT_D = 4;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            kernel,
  input  logic [PA_W-1:0] wdata,
  output logic [PA_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (wr_en && kernel) base <= wdata;
  end

  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && kernel) |=> $stable(base));
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] pte,
  input  logic              store,
  output logic              valid,
  output logic              allowed,
  output logic [WORD_W-1:0] pte_upd,
  output logic              needs_wb
);
  always_comb begin
    valid   = pte[BIT_V];
    allowed = store ? pte[BIT_W] : pte[BIT_R];
    pte_upd = pte;
    pte_upd[BIT_U] = 1'b1;
    if (store) pte_upd[BIT_D] = 1'b1;
    needs_wb = (pte_upd != pte);
  end
endmodule

// File: rtl/ptw_walk_ctl.sv
module ptw_walk_ctl
  import ptw_pkg::*;
#(
  parameter int L1_W        = 10,
  parameter int L2_W        = 10,
  parameter int OFF_W       = 12,
  parameter int PA_W        = 32,
  parameter int WORD_W      = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PA_W-1:0]             base,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [L1_W+L2_W+OFF_W-1:0]  req_vaddr,
  input  logic                        req_store,
  output logic                        done,
  output logic [1:0]                  status,
  output logic [PA_W-1:0]             paddr,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [PA_W-1:0]             mem_addr,
  output logic [WORD_W-1:0]           mem_wdata,
  input  logic                        mem_rsp_valid,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        leaf_store,
  input  logic                        pte_valid,
  input  logic                        pte_allowed,
  input  logic [WORD_W-1:0]           pte_upd,
  input  logic                        pte_needs_wb
);
  localparam int VA_W  = L1_W + L2_W + OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int SH    = $clog2(ENTRY_BYTES);

  typedef enum logic [1:0] {W_IDLE, W_L1, W_L2, W_WB} walk_st_e;

  walk_st_e        st;
  logic [VA_W-1:0] va_q;
  logic            store_q;
  logic [1:0]      status_q;

  logic [PPN_W-1:0] rsp_ppn;
  logic [L1_W-1:0]  new_l1;
  logic [L2_W-1:0]  cur_l2;
  logic [PA_W-1:0]  l1_addr, l2_addr, leaf_pa;

  assign rsp_ppn    = mem_rdata[WORD_W-1 -: PPN_W];
  assign new_l1     = req_vaddr[VA_W-1 -: L1_W];
  assign cur_l2     = va_q[OFF_W +: L2_W];
  assign l1_addr    = base + (PA_W'(new_l1) << SH);
  assign l2_addr    = {rsp_ppn, {OFF_W{1'b0}}} + (PA_W'(cur_l2) << SH);
  assign leaf_pa    = {rsp_ppn, va_q[OFF_W-1:0]};
  assign req_ready  = (st == W_IDLE);
  assign leaf_store = store_q;
  assign status     = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      va_q      <= '0;
      store_q   <= 1'b0;
      done      <= 1'b0;
      status_q  <= XS_OK;
      paddr     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        W_IDLE: if (req_valid) begin
          va_q     <= req_vaddr;
          store_q  <= req_store;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= l1_addr;
          st       <= W_L1;
        end
        W_L1: if (mem_rsp_valid) begin
          if (!pte_valid) begin
            done     <= 1'b1;
            status_q <= XS_PGFLT;
            paddr    <= '0;
            st       <= W_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= l2_addr;
            st       <= W_L2;
          end
        end
        W_L2: if (mem_rsp_valid) begin
          if (!pte_valid || !pte_allowed) begin
            done     <= 1'b1;
            status_q <= pte_valid ? XS_PROT : XS_PGFLT;
            paddr    <= '0;
            st       <= W_IDLE;
          end else if (pte_needs_wb) begin
            paddr     <= leaf_pa;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= pte_upd;
            st        <= W_WB;
          end else begin
            paddr    <= leaf_pa;
            done     <= 1'b1;
            status_q <= XS_OK;
            st       <= W_IDLE;
          end
        end
        W_WB: if (mem_rsp_valid) begin
          mem_we   <= 1'b0;
          done     <= 1'b1;
          status_q <= XS_OK;
          st       <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  status_legal_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (status != 2'd3));
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  no_access_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  // R7
  wb_marks_use_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_U]);
  // R2
  access_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int L1_W        = 10,
  parameter int L2_W        = 10,
  parameter int OFF_W       = 12,
  parameter int PA_W        = 32,
  parameter int WORD_W      = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       base_we,
  input  logic                       base_kernel,
  input  logic [PA_W-1:0]            base_wdata,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [L1_W+L2_W+OFF_W-1:0] req_vaddr,
  input  logic                       req_store,
  output logic                       done,
  output logic [1:0]                 status,
  output logic [PA_W-1:0]            paddr,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [PA_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]          mem_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [WORD_W-1:0]          mem_rdata
);
  logic [PA_W-1:0]   base;
  logic              leaf_store, pte_valid, pte_allowed, pte_needs_wb;
  logic [WORD_W-1:0] pte_upd;

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_we), .kernel(base_kernel),
    .wdata(base_wdata), .base(base)
  );

  ptw_pte_eval #(.WORD_W(WORD_W)) u_eval (
    .pte(mem_rdata), .store(leaf_store), .valid(pte_valid),
    .allowed(pte_allowed), .pte_upd(pte_upd), .needs_wb(pte_needs_wb)
  );

  ptw_walk_ctl #(
    .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W), .PA_W(PA_W),
    .WORD_W(WORD_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_ctl (
    .clk(clk), .rst(rst), .base(base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .done(done), .status(status), .paddr(paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata(mem_rdata), .leaf_store(leaf_store),
    .pte_valid(pte_valid), .pte_allowed(pte_allowed),
    .pte_upd(pte_upd), .pte_needs_wb(pte_needs_wb)
  );
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        base_we = 0, base_kernel = 0;
  logic [31:0] base_wdata = 0;
  logic        req_valid = 0, req_store = 0;
  logic [31:0] req_vaddr = 0;
  logic        req_ready, done;
  logic [1:0]  status;
  logic [31:0] paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rdata = 0;

  int errors = 0, checks = 0, op_cnt = 0;
  bit finished = 0;
  logic [31:0] mem [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_kernel(base_kernel),
    .base_wdata(base_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .done(done),
    .status(status), .paddr(paddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req) begin
      op_cnt <= op_cnt + 1;
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[13:2]];
      mem_rsp_valid <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr,
                      output logic [1:0] st, output logic [31:0] pa,
                      output int ops, output logic [31:0] first);
    int start;
    int n;
    start = op_cnt;
    @(negedge clk);
    req_vaddr = va; req_store = wr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    first = mem_addr;
    chk("R9 ready low during walk", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R8 walk timeout", 32'd0, 32'd1);
    st = status; pa = paddr;
    @(negedge clk);
    ops = op_cnt - start;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [1:0]  st;
    logic [31:0] pa;
    logic [3:0]  ops;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h0000_0123, 1'b0, 2'd0, 32'h1234_5123, 4'd3}, // R1 R7 load, first touch
    '{32'h0000_0123, 1'b0, 2'd0, 32'h1234_5123, 4'd2}, // R7 referenced already set
    '{32'h0000_0123, 1'b1, 2'd2, 32'h0,         4'd2}, // R6 store to read-only
    '{32'h0000_1FFF, 1'b1, 2'd0, 32'hABCD_EFFF, 4'd3}, // R1 R7 store sets modified
    '{32'h0000_2000, 1'b0, 2'd1, 32'h0,         4'd2}, // R5 leaf invalid
    '{32'h0080_0000, 1'b0, 2'd1, 32'h0,         4'd1}, // R4 first level invalid
    '{32'h0000_3010, 1'b0, 2'd2, 32'h0,         4'd2}, // R6 load to write-only
    '{32'h0000_4000, 1'b1, 2'd0, 32'h7777_7000, 4'd2}, // R7 nothing to update
    '{32'h0040_5ABC, 1'b0, 2'd0, 32'h0F0F_0ABC, 4'd3}  // R2 second table
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0]  st;
    logic [31:0] pa, first;
    int ops;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[12'h400] = 32'h0000_2001;
    mem[12'h401] = 32'h0000_3001;
    mem[12'h800] = 32'h1234_5003;
    mem[12'h801] = 32'hABCD_E007;
    mem[12'h803] = 32'h5555_5005;
    mem[12'h804] = 32'h7777_701F;
    mem[12'hC05] = 32'h0F0F_0007;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R9 reset status/paddr", {30'd0, status} | paddr, 32'd0);

    // R3 reset base is zero: first access at address 0
    walk(32'h0000_0000, 1'b0, st, pa, ops, first);
    chk("R3 reset base first address", first, 32'h0);

    base_wdata = 32'h1000; base_kernel = 1; base_we = 1;
    @(negedge clk);
    base_we = 0; base_kernel = 0;

    for (int i = 0; i < 9; i++) begin
      walk(VECS[i].va, VECS[i].wr, st, pa, ops, first);
      chk($sformatf("R8 vec%0d status", i), {30'd0, st}, {30'd0, VECS[i].st});
      chk($sformatf("R1 vec%0d paddr", i), pa, VECS[i].pa);
      chk($sformatf("R7 vec%0d access count", i), ops, {28'd0, VECS[i].ops});
      chk($sformatf("R2 vec%0d first address", i), first,
          32'h1000 + {20'd0, VECS[i].va[31:22], 2'b00});
    end

    chk("R7 referenced bit written", mem[12'h800], 32'h1234_500B);
    chk("R7 modified bit written", mem[12'h801], 32'hABCD_E01F);
    chk("R7 load leaves modified clear", mem[12'hC05], 32'h0F0F_000F);
    chk("R6 faulting entry unchanged", mem[12'h803], 32'h5555_5005);
    chk("R7 no rewrite when set", mem[12'h804], 32'h7777_701F);

    // R3 user-mode base write is ignored
    base_wdata = 32'h3000; base_kernel = 0; base_we = 1;
    @(negedge clk);
    base_we = 0;
    walk(32'h0000_0123, 1'b0, st, pa, ops, first);
    chk("R3 user write ignored", first, 32'h1000);
    chk("R3 user write walk ok", {30'd0, st}, 32'd0);

    // R3 kernel write takes effect; R4 empty table gives one-access fault
    base_kernel = 1; base_we = 1;
    @(negedge clk);
    base_we = 0; base_kernel = 0;
    walk(32'h0000_0123, 1'b0, st, pa, ops, first);
    chk("R3 kernel write used", first, 32'h3000);
    chk("R4 fault status", {30'd0, st}, 32'd1);
    chk("R4 single access", ops, 32'd1);

    // R8 done lasts one cycle
    chk("R8 done dropped", {31'd0, done}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule